// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block holds the on/off state of the clock for each peripheral in a subsystem. It drives one clock-enable line per peripheral, and each line is meant to feed a latch-based clock gate outside the block. The enables are grouped in banks of 32 bits. Software reaches each bank through three words on a simple synchronous register bus:

- a set word, where every 1 written switches the matching clock on;
- a clear word, where every 1 written switches the matching clock off;
- a read-only status word that shows the present state.

Zeros written to the set or clear words leave their bits alone. Each peripheral can therefore be switched without a read-modify-write sequence, and no other peripheral's clock is disturbed.

A bit's position in the enable vector is the peripheral's identifier. That identifier is also the number of its interrupt source. A parameter mask marks which positions have a real peripheral behind them. Positions with no peripheral never turn on. A write to the clear word stops that clock at the very next clock edge, with nothing deferred. Making sure a peripheral has gone idle before its clock is removed is a job for software.

Top module: `pcg_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every bit of `clk_en` is 0 and the status words read 0.
- R2: A bus write to a bank's set word (word offset 0 within the bank) sets each `clk_en` bit whose data bit is 1, in the cycle after the write. Data bits that are 0 leave their enables unchanged.
- R3: A bus write to a bank's clear word (word offset 1) clears each `clk_en` bit whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R4: A bus read of a bank's status word (word offset 2) returns that bank's enable bits. `rd_data` is registered: the value appears one cycle after the address and reflects the state before any write made in the same cycle.
- R5: `addr` is a word index. Bits [ADDR_W-1:2] select the bank and bits [1:0] select the word. Bank b, data bit i, drives `clk_en[b*32+i]`. A write to one bank never changes another bank.
- R6: A clear takes effect at the clock edge that samples the write. The affected `clk_en` bits are already low in the following cycle, with no extra delay stage.
- R7: Positions whose bit in `PRESENT_MASK` is 0 stay 0 on `clk_en` and read as 0, whatever is written. With the default mask, those positions are bits 0 to 2 and 59 to 63.
- R8: Reads of a set word, a clear word, word offset 3, or a bank index at or above `NUM_BANKS` return 0. Writes to word offset 3, or to such a bank index, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word index: bank in the upper bits, word in the lower two |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | BANK_W | Write data |
| rd_data | output | BANK_W | Registered read data |
| clk_en | output | NUM_BANKS*BANK_W | One clock-enable per peripheral position |

## Verification
Each bit of state is a live output: a bit that is set or cleared wrongly shows on `clk_en` in the cycle right after the offending write. It also shows on `rd_data` one cycle after a status read. If a write lands in the wrong bank or the wrong word, a neighbouring bank's enables change where they should have held. An absent position that wrongly turns on is visible on the very next cycle. A bench that compares the whole enable vector every clock therefore catches any wrong state within one cycle of the write that caused it.

// File: rtl/pcg_pkg.sv
// Package: shared word-offset encoding for the clock gating controller.
// Assumes the two low address bits select the word within a bank.
package pcg_pkg;
    typedef enum logic [1:0] {
        WORD_SET   = 2'd0,
        WORD_CLR   = 2'd1,
        WORD_STAT  = 2'd2,
        WORD_SPARE = 2'd3
    } pcg_word_e;
endpackage

// File: rtl/pcg_decode.sv
// Module: pcg_decode
// Turns a bus write into per-bank set and clear strobes.
// Assumes addr is a word index: bank in the upper bits, word in bits [1:0].
// Writes to the spare word or to a missing bank raise no strobe.
module pcg_decode
    import pcg_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 4
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] set_sel,
    output logic [NUM_BANKS-1:0] clr_sel
);
    localparam int BSEL_W = ADDR_W - 2;

    logic [BSEL_W-1:0] bank_idx;
    pcg_word_e         word;

    assign bank_idx = addr[ADDR_W-1:2];
    assign word     = pcg_word_e'(addr[1:0]);

    // Purpose: one-hot strobe generation, one set/clear pair per bank.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            set_sel[b] = wr_en && (int'(bank_idx) == b) && (word == WORD_SET);
            clr_sel[b] = wr_en && (int'(bank_idx) == b) && (word == WORD_CLR);
        end
    end

    // R5: at most one bank is touched by a single write
    always_comb begin
        assert_one_bank_R5: assert ($onehot0(set_sel | clr_sel));
    end
endmodule

// File: rtl/pcg_bank.sv
// Module: pcg_bank
// Holds the enable state of one bank of peripheral clocks.
// Assumes set_stb and clr_stb are never high together (a single bus);
// if they were, clear would win. Absent positions (MASK bit 0) stay 0.
module pcg_bank #(
    parameter int            W    = 32,
    parameter logic [W-1:0]  MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] state
);
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;
    logic [W-1:0] state_q;

    assign set_bits = set_stb ? wdata : '0;
    assign clr_bits = clr_stb ? wdata : '0;

    // Purpose: state register; set where asked, clear where asked, clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= (state_q | (set_bits & MASK)) & ~clr_bits;
    end

    assign state = state_q;

    // R1: reset empties the bank
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0));

    // R2: written ones appear after a set write
    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb) |=> ((state_q & $past(wdata & MASK)) == $past(wdata & MASK)));

    // R3/R6: cleared bits are low the very next cycle
    assert_clear_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((state_q & $past(wdata)) == '0));

    // R2/R3: bits written as zero keep their value
    assert_zero_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((state_q & ~$past(wdata)) == ($past(state_q) & ~$past(wdata))));

    // R8: no strobe, no change
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(state_q));
endmodule

// File: rtl/pcg_readmux.sv
// Module: pcg_readmux
// Registered read port: returns a bank's state for its status word and
// zero for any other address. Assumes the flat state vector is bank-major.
module pcg_readmux
    import pcg_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BANKS*BANK_W-1:0] state_all,
    output logic [BANK_W-1:0]           rd_data
);
    localparam int BSEL_W = ADDR_W - 2;

    logic [BSEL_W-1:0] bank_idx;
    logic [BANK_W-1:0] rd_next;
    logic [BANK_W-1:0] rd_q;

    assign bank_idx = addr[ADDR_W-1:2];

    // Purpose: select the addressed status word, zero elsewhere.
    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if ((int'(bank_idx) == b) && (pcg_word_e'(addr[1:0]) == WORD_STAT))
                rd_next = state_all[b*BANK_W +: BANK_W];
        end
    end

    // Purpose: register the read result for a one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_next;
    end

    assign rd_data = rd_q;

    // R4: a status read of bank 0 returns the enables of the previous cycle
    assert_status_bank0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr) == ADDR_W'(WORD_STAT)) |-> (rd_q == $past(state_all[BANK_W-1:0])));

    // R8: set and clear words read as zero
    assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1] == 1'b0) |=> (rd_q == '0));
endmodule

// File: rtl/pcg_ctrl.sv
// Module: pcg_ctrl (top)
// Peripheral clock gating controller: NUM_BANKS banks of BANK_W enables,
// each with set, clear and status words on a synchronous register bus.
// Assumes one bus access per cycle; clk_en feeds external gating cells.
module pcg_ctrl #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 4,
    parameter logic [NUM_BANKS*BANK_W-1:0] PRESENT_MASK = 64'h07FF_FFFF_FFFF_FFF8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [BANK_W-1:0]           wr_data,
    output logic [BANK_W-1:0]           rd_data,
    output logic [NUM_BANKS*BANK_W-1:0] clk_en
);
    localparam int TOTAL_W = NUM_BANKS * BANK_W;

    logic [NUM_BANKS-1:0] set_sel;
    logic [NUM_BANKS-1:0] clr_sel;
    logic [TOTAL_W-1:0]   state_all;

    pcg_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .set_sel (set_sel),
        .clr_sel (clr_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pcg_bank #(
            .W    (BANK_W),
            .MASK (PRESENT_MASK[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_sel[b]),
            .clr_stb (clr_sel[b]),
            .wdata   (wr_data),
            .state   (state_all[b*BANK_W +: BANK_W])
        );
    end

    pcg_readmux #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_readmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .state_all (state_all),
        .rd_data   (rd_data)
    );

    assign clk_en = state_all;

    // R7: absent positions never enable
    assert_absent_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en & ~PRESENT_MASK) == '0);
endmodule

// File: tb/pcg_ctrl_bench.sv
module pcg_ctrl_bench;
    localparam int NB = 2;
    localparam int BW = 32;
    localparam int AW = 4;
    localparam logic [63:0] MASK = 64'h07FF_FFFF_FFFF_FFF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [BW-1:0] wr_data = '0;
    logic [BW-1:0] rd_data;
    logic [63:0]   clk_en;

    int errors = 0;
    int checks = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    logic [63:0] ref_en = '0;
    logic [31:0] ref_rd = '0;

    always #4 clk = ~clk;

    pcg_ctrl u_pcg_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        int bank;
        int word;
        logic [31:0] rd_new;
        bank = int'(addr) / 4;
        word = int'(addr) % 4;
        rd_new = 32'h0;
        if (!rst_n) begin
            ref_rd = 32'h0;
            ref_en = 64'h0;
        end else begin
            if (bank < NB && word == 2) rd_new = ref_en[bank*32 +: 32];
            ref_rd = rd_new;
            if (wr_en && bank < NB) begin
                for (int i = 0; i < 32; i++) begin
                    if (wr_data[i] && word == 0 && MASK[bank*32+i]) ref_en[bank*32+i] = 1'b1;
                    if (wr_data[i] && word == 1) ref_en[bank*32+i] = 1'b0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (live) begin
            chk("R6 clk_en per cycle", clk_en, ref_en);
            chk("R4 rd_data per cycle", {32'h0, rd_data}, {32'h0, ref_rd});
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = AW'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        @(negedge clk);
        #1 d = rd_data;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2345;
        repeat (3) @(negedge clk);
        chk("R1 clk_en after reset", clk_en, 64'h0);
        rst_n = 1'b1;
        live = 1'b1;
        rd(2, v);  chk("R1 status bank0 after reset", {32'h0, v}, 64'h0);
        rd(6, v);  chk("R1 status bank1 after reset", {32'h0, v}, 64'h0);

        wr(0, 32'hFFFF_FFFF);
        chk("R7 absent low bits stay off", clk_en, 64'h0000_0000_FFFF_FFF8);
        rd(2, v);  chk("R4 status shows set bits", {32'h0, v}, 64'hFFFF_FFF8);
        wr(1, 32'h0000_00F0);
        chk("R6 clear visible next cycle", clk_en, 64'h0000_0000_FFFF_FF08);
        wr(0, 32'h0);
        chk("R2 zero set write no effect", clk_en, 64'h0000_0000_FFFF_FF08);
        wr(1, 32'h0);
        chk("R3 zero clear write no effect", clk_en, 64'h0000_0000_FFFF_FF08);
        wr(4, 32'h8000_0001);
        chk("R5 bank1 bit0 drives clk_en 32, bit 63 absent", clk_en, 64'h0000_0001_FFFF_FF08);
        wr(5, 32'hFFFF_FFFF);
        chk("R5 bank1 clear leaves bank0", clk_en, 64'h0000_0000_FFFF_FF08);
        rd(0, v);  chk("R8 set word reads zero", {32'h0, v}, 64'h0);
        rd(1, v);  chk("R8 clear word reads zero", {32'h0, v}, 64'h0);
        rd(3, v);  chk("R8 spare word reads zero", {32'h0, v}, 64'h0);
        wr(8, 32'hFFFF_FFFF);
        wr(9, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        chk("R8 writes to missing bank ignored", clk_en, 64'h0000_0000_FFFF_FF08);
        rd(10, v); chk("R8 missing bank reads zero", {32'h0, v}, 64'h0);
        wr(4, 32'h07FF_FFFF);
        rd(6, v);  chk("R4 bank1 status", {32'h0, v}, 64'h07FF_FFFF);
        wr(4, 32'hF800_0000);
        chk("R7 absent high bits stay off", clk_en, 64'h07FF_FFFF_FFFF_FF08);

        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(negedge clk);
            addr = AW'(lfsr[3:0] & 4'h7);
            wr_en = lfsr[5];
            wr_data = lfsr ^ {lfsr[15:0], lfsr[31:16]};
        end
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        live = 1'b0;
        chk("R1 reset clears after traffic", clk_en, 64'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule